// File: doc/BRIEF.md
# Video Output Word Conditioner

This block is the last stage of a high-definition serial video receive path. It takes word-aligned luma and chroma samples together with region flags from the timing logic: an active-picture flag, timing-reference slot flag with word index, line-number slot flag with word index, and checksum slot flag with word index. It also takes the timing, line-number and checksum values that upstream logic computed for the current line. It then produces the final 20-bit output word pair, luma in the upper ten bits and chroma in the lower ten, registered once.

Inside active picture it can clamp reserved code values into the legal range. Outside the timing slots it can force both channels to their blanking levels. In the timing slots it can discard the received words and put freshly built ones in their place: a timing reference (3FF, 000, 000, status word), a two-word line number, or a two-word line checksum.

A registered output-enable marks every cycle that carries a valid word pair. Computing the checksum and tracking line timing are the job of neighbouring blocks.

Top module: `vid_out_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next output state is `dout_oe` = 0 and `dout` = {040, 200} (hex, luma upper).
- R2: `dout_oe` equals `vld_in` of the previous cycle; a cycle with `vld_in` low produces `dout` = {040, 200}.
- R3: A valid word pair outside every slot and outside active picture, with `mute_n` high, appears unaltered on `dout` one clock later (luma in bits 19:10, chroma in bits 9:0).
- R4: With `code_protect` high, a word in active picture with value 000 to 003 leaves as 004, one with value 3FC to 3FF leaves as 3FB, and any other word is unchanged; both channels are treated alike.
- R5: With `code_protect` low, active-picture words pass unaltered, reserved values included.
- R6: With `mute_n` low, every valid word outside the timing-reference, line-number and checksum slots leaves as 040 on luma and 200 on chroma, whatever the active and code-protect settings.
- R7: In a timing-reference slot with `trs_ins` high, both channels carry 3FF for `trs_pos` 0, 000 for `trs_pos` 1 and 2, and `trs_xyz` for `trs_pos` 3; with `trs_ins` low the received words pass unaltered.
- R8: In a line-number slot with `ln_ins` high, both channels carry the computed line number: `ln_pos` 0 puts `ln_calc[6:0]` in bits 8:2, and `ln_pos` 1 puts `ln_calc[10:7]` in bits 5:2. All other low bits are 0 and bit 9 is the inverse of bit 8. With `ln_ins` low the received words pass.
- R9: In a checksum slot with `crc_ins` high, `crc_pos` 0 carries checksum bits 8:0 and `crc_pos` 1 carries bits 17:9, in word bits 8:0, with bit 9 the inverse of bit 8. Luma takes `crc_y` and chroma takes `crc_c`. With `crc_ins` low the received words pass.
- R10: Slot flags rank timing reference over line number over checksum over active picture. A word in any slot is never remapped or muted, so an inserted 3FF or 000 stays as built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_in | input | 1 | Input word pair is valid this cycle |
| luma_in | input | 10 | Received luma word |
| chroma_in | input | 10 | Received chroma word |
| in_active | input | 1 | Word lies in active picture |
| in_trs | input | 1 | Word lies in a timing-reference slot |
| trs_pos | input | 2 | Word index within the timing reference, 0 to 3 |
| in_ln | input | 1 | Word lies in a line-number slot |
| ln_pos | input | 1 | Line-number word index, 0 or 1 |
| in_crc | input | 1 | Word lies in a checksum slot |
| crc_pos | input | 1 | Checksum word index, 0 or 1 |
| trs_xyz | input | 10 | Computed timing status word |
| ln_calc | input | 11 | Computed line number |
| crc_y | input | 18 | Computed luma line checksum |
| crc_c | input | 18 | Computed chroma line checksum |
| code_protect | input | 1 | Enable clamping of reserved codes in active picture |
| mute_n | input | 1 | Low forces video words to blanking |
| trs_ins | input | 1 | Replace timing-reference words |
| ln_ins | input | 1 | Replace line-number words |
| crc_ins | input | 1 | Replace checksum words |
| dout | output | 20 | Output word pair, luma in 19:10, chroma in 9:0 |
| dout_oe | output | 1 | Output word pair is valid |

## Verification
Random words are drawn half from the whole 10-bit range and half from a set that crowds the clamp edges (000 to 004 and 3FB to 3FF). Under that mix a remap that is off by one at either end, or that leaks outside active picture, shows up at once. Region flags are drawn singly and also several at a time, so the slot ranking is tried against every pairing. The insert, mute and protect controls change freely every cycle, which separates a control that is acted on late or ignored from one that works. Directed cycles walk the four timing-reference words, line numbers 000 and 7FF in both words, and checksums with bit 8 and bit 17 set and clear, so that any mistake in placing the fields or in building the inverted ninth bit is caught.

// File: rtl/vos_pkg.sv
// Package: shared types for the video output word conditioner.
// Assumes: one select and one insert kind serve both lanes in a cycle.
package vos_pkg;

    // What a lane does with its word this cycle.
    typedef enum logic [2:0] {
        SEL_PASS  = 3'd0,
        SEL_INS   = 3'd1,
        SEL_BLANK = 3'd2,
        SEL_REMAP = 3'd3
    } sel_e;

    // Which slot type an inserted word is built for.
    typedef enum logic [1:0] {
        KIND_TRS = 2'd0,
        KIND_LN  = 2'd1,
        KIND_CRC = 2'd2
    } kind_e;

endpackage

// File: rtl/vos_sel_dec.sv
// Module: vos_sel_dec
// Ranks the region flags and the controls into one lane action and one
// insert kind. Timing reference ranks over line number, which ranks over
// checksum, which ranks over active picture. Slot words are never muted.
// Assumes: flags are valid together with the word they describe.
module vos_sel_dec
    import vos_pkg::*;
(
    input  logic  in_active,
    input  logic  in_trs,
    input  logic  in_ln,
    input  logic  in_crc,
    input  logic  code_protect,
    input  logic  mute_n,
    input  logic  trs_ins,
    input  logic  ln_ins,
    input  logic  crc_ins,
    output sel_e  sel,
    output kind_e kind
);

    // Pick the lane action from the highest-ranked flag present.
    always_comb begin
        sel  = SEL_PASS;
        kind = KIND_TRS;
        if (in_trs) begin
            kind = KIND_TRS;
            sel  = trs_ins ? SEL_INS : SEL_PASS;
        end else if (in_ln) begin
            kind = KIND_LN;
            sel  = ln_ins ? SEL_INS : SEL_PASS;
        end else if (in_crc) begin
            kind = KIND_CRC;
            sel  = crc_ins ? SEL_INS : SEL_PASS;
        end else if (!mute_n) begin
            sel  = SEL_BLANK;
        end else if (in_active && code_protect) begin
            sel  = SEL_REMAP;
        end
    end

endmodule

// File: rtl/vos_ins_gen.sv
// Module: vos_ins_gen
// Builds the word that replaces a received slot word: the timing reference
// sequence, a line-number word or a checksum word. The line-number and
// checksum words carry the inverse of bit 8 in their top bit.
// Assumes: WORD_W is 10, LN_W is 11 and CRC_W is twice the data field.
module vos_ins_gen
    import vos_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int LN_W   = 11,
    parameter int CRC_W  = 18
) (
    input  kind_e             kind,
    input  logic [1:0]        trs_pos,
    input  logic [WORD_W-1:0] trs_xyz,
    input  logic              ln_pos,
    input  logic [LN_W-1:0]   ln_calc,
    input  logic              crc_pos,
    input  logic [CRC_W-1:0]  crc_val,
    output logic [WORD_W-1:0] ins_word
);

    localparam int LN_LO_W  = 7;
    localparam int LN_HI_W  = LN_W - LN_LO_W;
    localparam int CRC_HALF = CRC_W / 2;
    localparam int PAR_BIT  = WORD_W - 1;

    logic [CRC_HALF-1:0] crc_half;
    logic [WORD_W-1:0]   raw;

    // Choose the half of the checksum that this word carries.
    always_comb begin
        crc_half = crc_pos ? crc_val[CRC_W-1:CRC_HALF] : crc_val[CRC_HALF-1:0];
    end

    // Place the fields, leaving the top bit to the parity stage.
    always_comb begin
        raw = '0;
        unique case (kind)
            KIND_TRS: begin
                if (trs_pos == 2'd0)      raw = '1;
                else if (trs_pos == 2'd3) raw = trs_xyz;
                else                      raw = '0;
            end
            KIND_LN: begin
                if (!ln_pos) raw[2 +: LN_LO_W] = ln_calc[LN_LO_W-1:0];
                else         raw[2 +: LN_HI_W] = ln_calc[LN_W-1:LN_LO_W];
            end
            KIND_CRC: raw[CRC_HALF-1:0] = crc_half;
            default:  raw = '0;
        endcase
    end

    // Timing words leave as built; the others get the inverted top bit.
    always_comb begin
        ins_word = raw;
        if (kind != KIND_TRS) ins_word[PAR_BIT] = ~raw[PAR_BIT-1];
    end

endmodule

// File: rtl/vos_lane.sv
// Module: vos_lane
// One output channel: applies the chosen action (pass, insert, blank,
// clamp) to its word and registers the result.
// Assumes: synchronous active-low reset; invalid cycles show blanking.
module vos_lane
    import vos_pkg::*;
#(
    parameter int              WORD_W = 10,
    parameter logic [WORD_W-1:0] BLANK = 10'h040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_in,
    input  sel_e              sel,
    input  logic [WORD_W-1:0] word_in,
    input  logic [WORD_W-1:0] ins_word,
    output logic [WORD_W-1:0] word_out
);

    localparam logic [WORD_W-1:0] LO_LEGAL = WORD_W'(4);
    localparam logic [WORD_W-1:0] HI_LEGAL = WORD_W'((1 << WORD_W) - 5);

    logic [WORD_W-1:0] clamped;
    logic [WORD_W-1:0] next_word;

    // Pull reserved codes at either end into the legal range.
    always_comb begin
        if (word_in < LO_LEGAL)      clamped = LO_LEGAL;
        else if (word_in > HI_LEGAL) clamped = HI_LEGAL;
        else                         clamped = word_in;
    end

    // Select the outgoing word for this cycle.
    always_comb begin
        unique case (sel)
            SEL_INS:   next_word = ins_word;
            SEL_BLANK: next_word = BLANK;
            SEL_REMAP: next_word = clamped;
            default:   next_word = word_in;
        endcase
    end

    // Register the word; reset and idle cycles hold blanking.
    always_ff @(posedge clk) begin
        if (!rst_n || !vld_in) word_out <= BLANK;
        else                   word_out <= next_word;
    end

endmodule

// File: rtl/vid_out_stage.sv
// Module: vid_out_stage
// Output conditioner for aligned luma and chroma words: clamps reserved
// codes in active picture, mutes to blanking, and replaces timing
// reference, line-number and checksum words with computed ones.
// One clock of latency. Luma leaves in dout[19:10], chroma in dout[9:0].
// Assumes: region flags and computed values arrive with their word.
module vid_out_stage
    import vos_pkg::*;
#(
    parameter int                WORD_W       = 10,
    parameter int                LN_W         = 11,
    parameter int                CRC_W        = 18,
    parameter logic [WORD_W-1:0] LUMA_BLANK   = 10'h040,
    parameter logic [WORD_W-1:0] CHROMA_BLANK = 10'h200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_in,
    input  logic [WORD_W-1:0]   luma_in,
    input  logic [WORD_W-1:0]   chroma_in,
    input  logic                in_active,
    input  logic                in_trs,
    input  logic [1:0]          trs_pos,
    input  logic                in_ln,
    input  logic                ln_pos,
    input  logic                in_crc,
    input  logic                crc_pos,
    input  logic [WORD_W-1:0]   trs_xyz,
    input  logic [LN_W-1:0]     ln_calc,
    input  logic [CRC_W-1:0]    crc_y,
    input  logic [CRC_W-1:0]    crc_c,
    input  logic                code_protect,
    input  logic                mute_n,
    input  logic                trs_ins,
    input  logic                ln_ins,
    input  logic                crc_ins,
    output logic [2*WORD_W-1:0] dout,
    output logic                dout_oe
);

    localparam int LANES = 2;

    sel_e  sel;
    kind_e kind;

    logic [LANES-1:0][WORD_W-1:0] lane_in;
    logic [LANES-1:0][WORD_W-1:0] lane_out;
    logic [LANES-1:0][CRC_W-1:0]  lane_crc;

    // Gather per-lane sources; index 1 is luma, index 0 is chroma.
    always_comb begin
        lane_in  = {luma_in, chroma_in};
        lane_crc = {crc_y, crc_c};
    end

    vos_sel_dec u_dec (
        .in_active    (in_active),
        .in_trs       (in_trs),
        .in_ln        (in_ln),
        .in_crc       (in_crc),
        .code_protect (code_protect),
        .mute_n       (mute_n),
        .trs_ins      (trs_ins),
        .ln_ins       (ln_ins),
        .crc_ins      (crc_ins),
        .sel          (sel),
        .kind         (kind)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [WORD_W-1:0] BLK = (g == 1) ? LUMA_BLANK : CHROMA_BLANK;
        logic [WORD_W-1:0] ins_word;

        vos_ins_gen #(
            .WORD_W (WORD_W),
            .LN_W   (LN_W),
            .CRC_W  (CRC_W)
        ) u_ins (
            .kind     (kind),
            .trs_pos  (trs_pos),
            .trs_xyz  (trs_xyz),
            .ln_pos   (ln_pos),
            .ln_calc  (ln_calc),
            .crc_pos  (crc_pos),
            .crc_val  (lane_crc[g]),
            .ins_word (ins_word)
        );

        vos_lane #(
            .WORD_W (WORD_W),
            .BLANK  (BLK)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .vld_in   (vld_in),
            .sel      (sel),
            .word_in  (lane_in[g]),
            .ins_word (ins_word),
            .word_out (lane_out[g])
        );
    end

    // Track validity alongside the registered word pair.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_oe <= 1'b0;
        else        dout_oe <= vld_in;
    end

    // Assemble the output pair.
    always_comb begin
        dout = {lane_out[1], lane_out[0]};
    end

endmodule

// File: rtl/vid_out_stage_chk.sv
// Module: vid_out_stage_chk
// Property checker for vid_out_stage, attached by bind below.
module vid_out_stage_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        vld_in,
    input logic [9:0]  luma_in,
    input logic [9:0]  chroma_in,
    input logic        in_active,
    input logic        in_trs,
    input logic [1:0]  trs_pos,
    input logic        in_ln,
    input logic        in_crc,
    input logic        code_protect,
    input logic        mute_n,
    input logic        trs_ins,
    input logic        ln_ins,
    input logic [19:0] dout,
    input logic        dout_oe
);

    logic no_slot;
    always_comb no_slot = !in_trs && !in_ln && !in_crc;

    // R2
    oe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_in |=> dout_oe);

    // R2
    idle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_in |=> (!dout_oe && dout == 20'h10200));

    // R3
    pass_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && no_slot && !in_active && mute_n)
        |=> dout == $past({luma_in, chroma_in}));

    // R4
    remap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && no_slot && in_active && mute_n && code_protect)
        |=> (dout[19:10] >= 10'h004 && dout[19:10] <= 10'h3FB &&
             dout[9:0] >= 10'h004 && dout[9:0] <= 10'h3FB));

    // R6
    mute_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && no_slot && !mute_n) |=> dout == 20'h10200);

    // R7
    trs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && in_trs && trs_ins && trs_pos == 2'd0) |=> dout == 20'hFFFFF);

    // R8
    ln_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && !in_trs && in_ln && ln_ins)
        |=> (dout[19] != dout[18] && dout[9] != dout[8]));

endmodule

bind vid_out_stage vid_out_stage_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vld_in       (vld_in),
    .luma_in      (luma_in),
    .chroma_in    (chroma_in),
    .in_active    (in_active),
    .in_trs       (in_trs),
    .trs_pos      (trs_pos),
    .in_ln        (in_ln),
    .in_crc       (in_crc),
    .code_protect (code_protect),
    .mute_n       (mute_n),
    .trs_ins      (trs_ins),
    .ln_ins       (ln_ins),
    .dout         (dout),
    .dout_oe      (dout_oe)
);

// File: tb/vid_out_stage_bench.sv
module vid_out_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_in = 1'b0;
    logic [9:0]  luma_in = '0, chroma_in = '0;
    logic        in_active = 1'b0, in_trs = 1'b0, in_ln = 1'b0, in_crc = 1'b0;
    logic [1:0]  trs_pos = '0;
    logic        ln_pos = 1'b0, crc_pos = 1'b0;
    logic [9:0]  trs_xyz = '0;
    logic [10:0] ln_calc = '0;
    logic [17:0] crc_y = '0, crc_c = '0;
    logic        code_protect = 1'b0, mute_n = 1'b1;
    logic        trs_ins = 1'b0, ln_ins = 1'b0, crc_ins = 1'b0;
    logic [19:0] dout;
    logic        dout_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vid_out_stage u_vid_out_stage (
        .clk(clk), .rst_n(rst_n), .vld_in(vld_in),
        .luma_in(luma_in), .chroma_in(chroma_in),
        .in_active(in_active), .in_trs(in_trs), .trs_pos(trs_pos),
        .in_ln(in_ln), .ln_pos(ln_pos), .in_crc(in_crc), .crc_pos(crc_pos),
        .trs_xyz(trs_xyz), .ln_calc(ln_calc), .crc_y(crc_y), .crc_c(crc_c),
        .code_protect(code_protect), .mute_n(mute_n),
        .trs_ins(trs_ins), .ln_ins(ln_ins), .crc_ins(crc_ins),
        .dout(dout), .dout_oe(dout_oe)
    );

    // Expected word for one lane, written from the requirements.
    function automatic logic [9:0] exp_lane(input logic [9:0] w,
                                            input logic [9:0] blank,
                                            input logic [17:0] crc);
        if (in_trs) begin
            if (!trs_ins) return w;
            if (trs_pos == 2'd0) return 10'h3FF;
            if (trs_pos == 2'd3) return trs_xyz;
            return 10'h000;
        end
        if (in_ln) begin
            if (!ln_ins) return w;
            if (!ln_pos) return {~ln_calc[6], ln_calc[6:0], 2'b00};
            return {1'b1, 3'b000, ln_calc[10:7], 2'b00};
        end
        if (in_crc) begin
            if (!crc_ins) return w;
            if (!crc_pos) return {~crc[8], crc[8:0]};
            return {~crc[17], crc[17:9]};
        end
        if (!mute_n) return blank;
        if (in_active && code_protect) begin
            if (w <= 10'h003) return 10'h004;
            if (w >= 10'h3FC) return 10'h3FB;
        end
        return w;
    endfunction

    function automatic string tag_of();
        int nf = int'(in_trs) + int'(in_ln) + int'(in_crc) + int'(in_active);
        if (!vld_in) return "R2";
        if (nf > 1 && (in_trs || in_ln || in_crc)) return "R10";
        if (in_trs) return "R7";
        if (in_ln) return "R8";
        if (in_crc) return "R9";
        if (!mute_n) return "R6";
        if (in_active && code_protect) return "R4";
        if (in_active) return "R5";
        return "R3";
    endfunction

    // Apply the current inputs for one clock, then compare at the next negedge.
    task automatic step();
        logic [19:0] e;
        logic        eoe;
        string       t;
        t   = tag_of();
        eoe = vld_in;
        if (!vld_in) e = 20'h10200;
        else e = {exp_lane(luma_in, 10'h040, crc_y), exp_lane(chroma_in, 10'h200, crc_c)};
        @(negedge clk);
        n_chk++;
        if (dout !== e || dout_oe !== eoe) begin
            n_bad++;
            $display("FAIL %s: dout=%h oe=%b expected dout=%h oe=%b", t, dout, dout_oe, e, eoe);
        end
    endtask

    task automatic clear_flags();
        in_active = 0; in_trs = 0; in_ln = 0; in_crc = 0;
    endtask

    function automatic logic [9:0] pick_word();
        logic [9:0] edges [10] = '{10'h000, 10'h001, 10'h002, 10'h003, 10'h004,
                                   10'h3FB, 10'h3FC, 10'h3FD, 10'h3FE, 10'h3FF};
        if ($urandom_range(1, 0) == 1) return edges[$urandom_range(9, 0)];
        return 10'($urandom);
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1: reset state
        repeat (2) @(negedge clk);
        vld_in = 1'b1; luma_in = 10'h123; chroma_in = 10'h321;
        @(negedge clk);
        n_chk++;
        if (dout !== 20'h10200 || dout_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: dout=%h oe=%b expected dout=10200 oe=0", dout, dout_oe);
        end
        rst_n = 1'b1;

        // R3: plain pass-through
        luma_in = 10'h2AB; chroma_in = 10'h155; step();
        // R5: reserved codes in active picture with protect off
        in_active = 1; luma_in = 10'h000; chroma_in = 10'h3FF; step();
        // R4: protect on, all four edges
        code_protect = 1; luma_in = 10'h003; chroma_in = 10'h3FC; step();
        luma_in = 10'h3FF; chroma_in = 10'h000; step();
        luma_in = 10'h004; chroma_in = 10'h3FB; step();
        // R6: mute overrides remap
        mute_n = 0; step();
        mute_n = 1; clear_flags();
        // R7: full timing reference sequence, inserted then received
        trs_ins = 1; in_trs = 1; trs_xyz = 10'h2D8; luma_in = 10'h111; chroma_in = 10'h222;
        for (int k = 0; k < 4; k++) begin trs_pos = 2'(k); step(); end
        // R10: timing slot during active picture with protect and mute
        in_active = 1; mute_n = 0; trs_pos = 0; step();
        mute_n = 1; in_active = 0; trs_ins = 0; trs_pos = 1; step();
        clear_flags();
        // R8: line numbers at both extremes, both words
        in_ln = 1; ln_ins = 1;
        ln_calc = 11'h7FF; ln_pos = 0; step(); ln_pos = 1; step();
        ln_calc = 11'h000; ln_pos = 0; step(); ln_pos = 1; step();
        ln_calc = 11'h4C1; ln_pos = 0; step(); ln_pos = 1; step();
        clear_flags();
        // R9: checksum halves with bit 8 / bit 17 set and clear
        in_crc = 1; crc_ins = 1;
        crc_y = 18'h3FFFF; crc_c = 18'h00000; crc_pos = 0; step(); crc_pos = 1; step();
        crc_y = 18'h20100; crc_c = 18'h1FEFF; crc_pos = 0; step(); crc_pos = 1; step();
        crc_ins = 0; step();
        clear_flags();
        // R2: idle cycle
        vld_in = 0; step(); vld_in = 1;

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            vld_in = ($urandom_range(9, 0) != 0);
            luma_in = pick_word(); chroma_in = pick_word();
            clear_flags();
            r = $urandom_range(7, 0);
            case (r)
                0, 1, 2: in_active = 1;
                3: in_trs = 1;
                4: in_ln = 1;
                5: in_crc = 1;
                7: begin
                    in_active = 1'($urandom); in_trs = 1'($urandom);
                    in_ln = 1'($urandom); in_crc = 1'($urandom);
                end
                default: ;
            endcase
            trs_pos = 2'($urandom); ln_pos = 1'($urandom); crc_pos = 1'($urandom);
            trs_xyz = 10'($urandom); ln_calc = 11'($urandom);
            crc_y = 18'($urandom); crc_c = 18'($urandom);
            code_protect = 1'($urandom); mute_n = ($urandom_range(3, 0) != 0);
            trs_ins = 1'($urandom); ln_ins = 1'($urandom); crc_ins = 1'($urandom);
            step();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule